// File: doc/BRIEF.md
# OFDM Cyclic Extension and Windowing Stage

This block sits after the inverse FFT of an OFDM transmitter. It accepts one time-domain symbol of `N_FFT` complex samples and emits an extended symbol of `N_FFT + N_G` samples. The extended symbol has three parts in this order. A prefix copies the tail of the symbol. The full symbol follows. A suffix copies the head of the symbol. Each guard part is `N_G/2` samples long. Every output sample, real and imaginary part alike, is scaled by a Blackman-Harris window coefficient. The coefficients are computed when the design is elaborated and span the whole extended length.

Input symbols go into a two-bank buffer, so the next symbol can be loaded while the current one is streamed out. `in_ready` tells the source when no bank is free. A zero-fill mode supports the step before the IFFT. When `in_pad` is high on the first sample of a symbol, only `N_QAM` samples are taken for that symbol and the remaining positions read as zero. The parameters must satisfy three conditions, or elaboration stops: the guard length is even and no longer than the symbol, and `N_FFT` is a power of two.

Top module: `ofdm_cyc_ext`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Each stored symbol produces exactly `N_FFT+N_G` output samples on consecutive cycles. `out_sos` is 1 on the first of them only. `out_valid` is never high outside such a run.
- R3: Output positions k = 0 to `N_G/2`-1 carry stored samples `N_FFT-N_G/2+k`, that is, the last half-guard of the symbol in its original order.
- R4: Output positions k = `N_G/2` to `N_G/2+N_FFT`-1 carry stored samples 0 to `N_FFT`-1 in order.
- R5: The last `N_G/2` output positions carry stored samples 0 to `N_G/2`-1 in order.
- R6: With L = `N_FFT+N_G` and scale S = 2^(`CW`-1), the coefficient is w(k) = round(S·(0.35875 − 0.48829·cos(2πk/(L−1)) + 0.14128·cos(4πk/(L−1)) − 0.01168·cos(6πk/(L−1)))). Each output part is floor(x·w(k)/S + 1/2), where x is the signed `DW`-bit input part. The result is clamped to the signed `DW`-bit range and applied to the real and imaginary parts independently.
- R7: Two symbols can be held at once. While one is streamed out, the next is accepted at full rate. `in_ready` is 0 when both banks hold unsent symbols. A sample offered while `in_ready` is 0 is not taken, and the same sample offered again later lands in the right position.
- R8: When `in_pad` is 1 on a symbol's first sample, that symbol closes after `N_QAM` accepted samples, and stored positions `N_QAM` to `N_FFT`-1 read as zero. The next accepted sample starts a new symbol.
- R9: Symbols leave in the order they were accepted, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_pad | input | 1 | Zero-fill mode, sampled with a symbol's first sample |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| in_ready | output | 1 | A bank is free, so an offered sample is taken |
| out_valid | output | 1 | Output sample valid |
| out_sos | output | 1 | First sample of an extended symbol |
| out_re | output | DW | Windowed real part, signed |
| out_im | output | DW | Windowed imaginary part, signed |

## Verification
The bench works on the seams of the extended symbol: the last prefix sample, the first and last body samples, and the first suffix sample. An off-by-one read address would show up there as a shifted or repeated sample. A window table indexed by body position rather than extended position would scale the wrong samples. The bench also streams three symbols back to back, so that both banks fill and `in_ready` drops. A design that releases a bank too early would then overwrite the symbol being read, and one that ignored `in_ready` would drop or duplicate samples. Short zero-filled symbols test that the fill region reads as zero and that symbol boundaries stay aligned afterwards. Full-scale alternating values test rounding on negative products.

// File: rtl/ofdm_cyc_ext_pkg.sv
package ofdm_cyc_ext_pkg;

  // Blackman-Harris window value at position k of len, scaled to 2^(cw-1).
  function automatic int bh_coef(int k, int len, int cw);
    real ph;
    real w;
    ph = 2.0 * 3.14159265358979 * real'(k) / real'(len - 1);
    w  = 0.35875 - 0.48829 * $cos(ph) + 0.14128 * $cos(2.0 * ph)
         - 0.01168 * $cos(3.0 * ph);
    return $rtoi(w * real'(1 << (cw - 1)) + 0.5);
  endfunction

  // Body index read at extended position k: prefix wraps to the tail.
  function automatic int ext_index(int k, int nfft, int half);
    return (k + nfft - half) % nfft;
  endfunction

  // Fixed-point window product with round-half-up and clamp.
  function automatic longint scale_sat(longint x, longint c, int cw, int dw);
    longint p;
    longint hi;
    longint lo;
    p  = (x * c + (longint'(1) <<< (cw - 2))) >>> (cw - 1);
    hi = (longint'(1) <<< (dw - 1)) - 1;
    lo = -(longint'(1) <<< (dw - 1));
    if (p > hi) p = hi;
    else if (p < lo) p = lo;
    return p;
  endfunction

endpackage

// File: rtl/ofdm_cyc_ext_buf.sv
module ofdm_cyc_ext_buf #(
  parameter int N_FFT = 16,
  parameter int N_QAM = 12,
  parameter int DW    = 12,
  localparam int AW   = $clog2(N_FFT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_pad,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 in_ready,
  output logic                 wr_fire,
  output logic                 wr_bank,
  output logic [1:0]           bank_full,
  input  logic                 rd_en,
  input  logic                 rd_bank,
  input  logic [AW-1:0]        rd_idx,
  input  logic                 rd_done,
  output logic signed [DW-1:0] rd_re,
  output logic signed [DW-1:0] rd_im
);

  localparam logic [AW-1:0] LAST_FULL = AW'(N_FFT - 1);
  localparam logic [AW-1:0] LAST_PAD  = AW'(N_QAM - 1);

  logic signed [DW-1:0] mem_re [2*N_FFT];
  logic signed [DW-1:0] mem_im [2*N_FFT];
  logic [AW-1:0] wcnt;
  logic          cur_pad;
  logic          pad_eff;
  logic          wr_last;
  logic [AW:0]   blen [2];
  logic [1:0]    set_v;
  logic [1:0]    clr_v;

  assign in_ready = !bank_full[wr_bank];
  assign wr_fire  = in_valid && in_ready;
  assign pad_eff  = (wcnt == '0) ? in_pad : cur_pad;
  assign wr_last  = wr_fire && (wcnt == (pad_eff ? LAST_PAD : LAST_FULL));
  assign set_v    = wr_last ? (2'b01 << wr_bank) : 2'b00;
  assign clr_v    = rd_done ? (2'b01 << rd_bank) : 2'b00;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem_re[{wr_bank, wcnt}] <= in_re;
      mem_im[{wr_bank, wcnt}] <= in_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= '0;
      wr_bank   <= 1'b0;
      cur_pad   <= 1'b0;
      bank_full <= 2'b00;
      blen[0]   <= '0;
      blen[1]   <= '0;
    end else begin
      bank_full <= (bank_full | set_v) & ~clr_v;
      if (wr_fire) begin
        if (wcnt == '0) cur_pad <= in_pad;
        if (wr_last) begin
          wcnt          <= '0;
          wr_bank       <= ~wr_bank;
          blen[wr_bank] <= pad_eff ? (AW+1)'(N_QAM) : (AW+1)'(N_FFT);
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // Registered read; positions beyond the stored length read as zero.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      if ({1'b0, rd_idx} < blen[rd_bank]) begin
        rd_re <= mem_re[{rd_bank, rd_idx}];
        rd_im <= mem_im[{rd_bank, rd_idx}];
      end else begin
        rd_re <= '0;
        rd_im <= '0;
      end
    end
  end

endmodule

// File: rtl/ofdm_cyc_ext_seq.sv
module ofdm_cyc_ext_seq
  import ofdm_cyc_ext_pkg::*;
#(
  parameter int N_FFT = 16,
  parameter int N_G   = 4,
  localparam int AW   = $clog2(N_FFT),
  localparam int LEN  = N_FFT + N_G,
  localparam int KW   = $clog2(LEN),
  localparam int NH   = N_G / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_full,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_idx,
  output logic [KW-1:0] rd_k,
  output logic          rd_first,
  output logic          rd_done
);

  logic          busy;
  logic [KW-1:0] k;

  assign rd_en    = busy;
  assign rd_k     = k;
  assign rd_first = busy && (k == '0);
  assign rd_done  = busy && (k == KW'(LEN - 1));
  assign rd_idx   = AW'(ext_index(int'(k), N_FFT, NH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_bank <= 1'b0;
      k       <= '0;
    end else if (!busy) begin
      if (bank_full[rd_bank]) begin
        busy <= 1'b1;
        k    <= '0;
      end
    end else if (rd_done) begin
      busy    <= 1'b0;
      rd_bank <= ~rd_bank;
    end else begin
      k <= k + 1'b1;
    end
  end

endmodule

// File: rtl/ofdm_cyc_ext_win.sv
module ofdm_cyc_ext_win
  import ofdm_cyc_ext_pkg::*;
#(
  parameter int LEN = 20,
  parameter int DW  = 12,
  parameter int CW  = 12,
  localparam int KW = $clog2(LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic                 in_sos,
  input  logic [KW-1:0]        in_k,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic                 out_sos,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  logic [CW-1:0] coef [LEN];
  logic [CW-1:0] wsel;

  for (genvar g = 0; g < LEN; g++) begin : g_coef
    localparam logic [CW-1:0] C = CW'(bh_coef(g, LEN, CW));
    assign coef[g] = C;
  end

  assign wsel = coef[in_k];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sos   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_v;
      out_sos   <= in_v && in_sos;
      if (in_v) begin
        out_re <= DW'(scale_sat(longint'(in_re), longint'(wsel), CW, DW));
        out_im <= DW'(scale_sat(longint'(in_im), longint'(wsel), CW, DW));
      end
    end
  end

endmodule

// File: rtl/ofdm_cyc_ext.sv
module ofdm_cyc_ext #(
  parameter int N_FFT = 16,
  parameter int N_G   = 4,
  parameter int N_QAM = 12,
  parameter int DW    = 12,
  parameter int CW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_pad,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_sos,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int AW  = $clog2(N_FFT);
  localparam int LEN = N_FFT + N_G;
  localparam int KW  = $clog2(LEN);

  if ((N_G % 2) != 0 || N_G < 2 || N_G > N_FFT) begin : g_bad_guard
    $error("guard length must be even, at least 2 and at most N_FFT");
  end
  if ((1 << AW) != N_FFT || N_QAM < 1 || N_QAM > N_FFT || CW < 2) begin : g_bad_size
    $error("N_FFT must be a power of two, N_QAM within 1..N_FFT, CW at least 2");
  end

  // Named internal events, observed by the bound checker.
  logic                 wr_fire;
  logic                 wr_bank;
  logic [1:0]           bank_full;
  logic                 rd_en;
  logic                 rd_bank;
  logic [AW-1:0]        rd_idx;
  logic [KW-1:0]        rd_k;
  logic                 rd_first;
  logic                 rd_done;
  logic signed [DW-1:0] rd_re;
  logic signed [DW-1:0] rd_im;
  logic                 s1_v;
  logic                 s1_sos;
  logic [KW-1:0]        s1_k;

  ofdm_cyc_ext_buf #(.N_FFT(N_FFT), .N_QAM(N_QAM), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_pad(in_pad), .in_re(in_re), .in_im(in_im),
    .in_ready(in_ready), .wr_fire(wr_fire), .wr_bank(wr_bank),
    .bank_full(bank_full),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_done(rd_done),
    .rd_re(rd_re), .rd_im(rd_im)
  );

  ofdm_cyc_ext_seq #(.N_FFT(N_FFT), .N_G(N_G)) u_seq (
    .clk(clk), .rst_n(rst_n), .bank_full(bank_full),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_k(rd_k),
    .rd_first(rd_first), .rd_done(rd_done)
  );

  // Align position and flags with the registered buffer read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sos <= 1'b0;
      s1_k   <= '0;
    end else begin
      s1_v   <= rd_en;
      s1_sos <= rd_first;
      s1_k   <= rd_k;
    end
  end

  ofdm_cyc_ext_win #(.LEN(LEN), .DW(DW), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .in_v(s1_v), .in_sos(s1_sos), .in_k(s1_k), .in_re(rd_re), .in_im(rd_im),
    .out_valid(out_valid), .out_sos(out_sos), .out_re(out_re), .out_im(out_im)
  );

endmodule

// File: rtl/ofdm_cyc_ext_chk.sv
module ofdm_cyc_ext_chk #(
  parameter int LEN = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_sos,
  input logic       wr_fire,
  input logic       wr_bank,
  input logic [1:0] bank_full,
  input logic       rd_en,
  input logic       rd_bank
);

  int   run;
  logic prev_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 0;
      prev_v <= 1'b0;
    end else begin
      prev_v <= out_valid;
      if (out_sos) run <= 1;
      else if (out_valid) run <= run + 1;
    end
  end

  p_sos_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sos |-> out_valid);

  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sos) |-> (run >= 1 && run < LEN));

  p_run_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_v && !out_valid) |-> (run == LEN));

  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !bank_full[wr_bank]);

  p_read_filled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> bank_full[rd_bank]);

endmodule

bind ofdm_cyc_ext ofdm_cyc_ext_chk #(.LEN(N_FFT + N_G)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sos(out_sos),
  .wr_fire(wr_fire), .wr_bank(wr_bank), .bank_full(bank_full),
  .rd_en(rd_en), .rd_bank(rd_bank)
);

// File: tb/ofdm_cyc_ext_test.sv
module ofdm_cyc_ext_test;

  localparam int N_FFT = 16;
  localparam int N_G   = 4;
  localparam int N_QAM = 12;
  localparam int DW    = 12;
  localparam int CW    = 12;
  localparam int L     = N_FFT + N_G;
  localparam int NH    = N_G / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid;
  logic                 in_pad;
  logic signed [DW-1:0] in_re;
  logic signed [DW-1:0] in_im;
  logic                 in_ready;
  logic                 out_valid;
  logic                 out_sos;
  logic signed [DW-1:0] out_re;
  logic signed [DW-1:0] out_im;

  ofdm_cyc_ext #(.N_FFT(N_FFT), .N_G(N_G), .N_QAM(N_QAM), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pad(in_pad),
    .in_re(in_re), .in_im(in_im), .in_ready(in_ready),
    .out_valid(out_valid), .out_sos(out_sos), .out_re(out_re), .out_im(out_im)
  );

  int total = 0;
  int bad   = 0;
  int stalls = 0;
  bit done = 0;

  typedef struct {int re; int im; bit sos; int k;} exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Window value from the requirement formula, rounded by cast.
  function automatic int win_w(int k);
    real a;
    real w;
    a = 2.0 * 3.14159265358979 * k / (L - 1);
    w = 0.35875 - 0.48829 * $cos(a) + 0.14128 * $cos(2.0 * a)
        - 0.01168 * $cos(3.0 * a);
    return int'(w * (2.0 ** (CW - 1)));
  endfunction

  function automatic int wmul(int x, int c);
    real r;
    int  v;
    r = $floor(real'(x * c) / (2.0 ** (CW - 1)) + 0.5);
    v = int'(r);
    if (v > (1 << (DW - 1)) - 1) v = (1 << (DW - 1)) - 1;
    if (v < -(1 << (DW - 1))) v = -(1 << (DW - 1));
    return v;
  endfunction

  // Offer one symbol; kind 0 ramp, 1 random, 2 full-scale alternating.
  task automatic send(bit pad, int kind);
    int n;
    int vr[$];
    int vi[$];
    n = pad ? N_QAM : N_FFT;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0:       begin vr.push_back(i * 97 - 700); vi.push_back(300 - i * 41); end
        1:       begin vr.push_back(int'($urandom_range(0, 4095)) - 2048);
                       vi.push_back(int'($urandom_range(0, 4095)) - 2048); end
        default: begin vr.push_back((i % 2 == 0) ? -2048 : 2047);
                       vi.push_back((i % 2 == 0) ? 2047 : -2048); end
      endcase
    end
    for (int i = 0; i < n; ) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pad   = pad;
      in_re    = DW'(vr[i]);
      in_im    = DW'(vi[i]);
      #1;
      if (in_ready) i++;
      else stalls++;
    end
    for (int k = 0; k < L; k++) begin
      exp_t e;
      int idx;
      idx   = (k - NH + N_FFT) % N_FFT;
      e.re  = (idx < n) ? wmul(vr[idx], win_w(k)) : 0;
      e.im  = (idx < n) ? wmul(vi[idx], win_w(k)) : 0;
      e.sos = (k == 0);
      e.k   = k;
      q.push_back(e);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_pad   = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference comparison on every clock, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "out_valid with no symbol pending", 1, 0);
        end else begin
          exp_t e;
          string tag;
          e = q.pop_front();
          tag = (e.k < NH) ? "R3/R6" : (e.k < NH + N_FFT) ? "R4/R6" : "R5/R6";
          chk(out_sos == e.sos, "R2", $sformatf("sos at k=%0d", e.k),
              int'(out_sos), int'(e.sos));
          chk(int'(out_re) == e.re, tag, $sformatf("re at k=%0d", e.k),
              int'(out_re), e.re);
          chk(int'(out_im) == e.im, tag, $sformatf("im at k=%0d", e.k),
              int'(out_im), e.im);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pad   = 1'b0;
    in_re    = '0;
    in_im    = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // Single ramp symbol: prefix, body and suffix seams (R3 R4 R5).
    send(1'b0, 0);
    idle();
    drain();

    // Back-to-back burst fills both banks (R7, R9).
    stalls = 0;
    send(1'b0, 1);
    send(1'b0, 1);
    send(1'b0, 1);
    idle();
    chk(stalls > 0, "R7", "stall cycles with both banks held", stalls, 1);
    drain();

    // Zero-filled symbols and alignment afterwards (R8).
    send(1'b1, 0);
    send(1'b0, 2);
    idle();
    drain();
    send(1'b1, 1);
    send(1'b1, 2);
    send(1'b0, 1);
    idle();
    drain();

    // Full-scale values, rounding of negative products (R6).
    send(1'b0, 2);
    idle();
    drain();

    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R9", "symbols left unsent", q.size(), 0);
    chk(out_valid == 1'b0, "R2", "out_valid when idle", int'(out_valid), 0);
    done = 1;
    finish_run();
  end

endmodule